// File: doc/BRIEF.md
# BCD Countdown Watchdog Timer

This block is a watchdog that counts down a timeout held as two packed-BCD bytes: one byte of seconds and one byte of hundredths of a second. The longest timeout is 99.99 s. An external 100 Hz tick paces the count, one hundredth per tick. Software programs the timeout and a small control word over a simple byte-wide register bus. Writing either count byte reloads the working counter and restarts the countdown, so that write is the kick.

When the count runs out, the block raises a status flag. A steering bit then picks the action. Either it drives a fixed-length reset pulse or it raises an interrupt request. Reading the status register clears the flag and the interrupt. After each expiry the counter reloads from the programmed value and keeps running. The watchdog is idle while its enable bit is clear or while both count bytes are zero.

Top module: `bcd_watchdog`

## Requirements
- R1: After reset all four registers read 0x00, and the reset pulse, interrupt and flag outputs are low.
- R2: Offset 0xC holds the hundredths byte and offset 0xD holds the seconds byte, both read back as written. Offset 0xF is the control register: bit 1 is enable and bit 0 is steering. Its other bits are ignored and read as 0. Offsets outside 0xC to 0xF read as 0x00.
- R3: When enabled with a nonzero timeout of N hundredths, the block expires on the N-th tick after the count starts. Expiry shows at the outputs in the clock cycle after that tick.
- R4: The hundredths byte counts down in BCD. Going below 00 it wraps to 99 and borrows one from the seconds byte, so a timeout of 01.05 expires on tick 105.
- R5: A write to 0xC or 0xD reloads the working counter from both bytes and restarts the count. If a tick arrives in the same cycle as that write, the write wins and no expiry happens.
- R6: If steering is 1, expiry drives the reset output high for exactly 16 clock cycles and leaves the interrupt low.
- R7: If steering is 0, expiry sets the interrupt output, which stays high until it is cleared. The reset output stays low.
- R8: Status register 0xE bit 1 is the watchdog flag, set on every expiry and also driven on a port. Reading 0xE clears the flag and the interrupt in the next cycle. If an expiry happens in the same cycle as that read, the flag stays set.
- R9: While enable is 0, or while both count bytes are 0, ticks have no effect and no expiry happens. Clearing enable in the middle of a count stops it.
- R10: After an expiry the counter reloads from the programmed bytes and keeps running, so the next expiry comes N ticks later with no further write.
- R11: Ticks that arrive while the block is disabled do not count. Setting enable starts a full timeout.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel_i | input | 1 | Bus access strobe, one cycle per access |
| bus_we_i | input | 1 | 1 = write, 0 = read |
| bus_addr_i | input | 4 | Register offset |
| bus_wdata_i | input | 8 | Write data |
| bus_rdata_o | output | 8 | Read data (combinational from the address) |
| tick_i | input | 1 | 100 Hz tick, one clock cycle wide |
| wd_rst_o | output | 1 | Reset pulse on a steered expiry |
| wd_irq_o | output | 1 | Interrupt request on a non-steered expiry |
| wd_flag_o | output | 1 | Watchdog expiry flag |

## Verification
A corrupted working counter or a wrong BCD borrow shows up as an expiry on the wrong tick. With a timeout of 01.05 a single wrong borrow moves the expiry by 100 ticks, so the bench checks that no expiry comes one tick early and that one comes on the exact tick. A wrong steering decision or a wrong pulse counter shows in the cycle after the expiring tick: the wrong output rises, or the pulse width differs from 16. A stale flag or interrupt shows one cycle after the status read that should have cleared it. The collision cases check what the ports show when two events share a cycle: a kick with a tick, and a status read with an expiry.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
    localparam int BYTE_W    = 8;
    localparam int DIGIT_W   = 4;
    localparam int NBYTES    = 2;
    localparam int COUNT_W   = NBYTES * BYTE_W;
    localparam int EN_BIT    = 1;
    localparam int STEER_BIT = 0;
    localparam int FLAG_BIT  = 1;

    typedef struct packed {
        logic [BYTE_W-1:0]  frac;
        logic [BYTE_W-1:0]  secs;
        logic [COUNT_W-1:0] work;
        logic               en;
        logic               steer;
        logic               flag;
        logic               irq;
    } wdt_state_t;
endpackage

// File: rtl/wdt_bcd_byte_dec.sv
module wdt_bcd_byte_dec
    import wdt_pkg::*;
(
    input  logic [BYTE_W-1:0] din,
    input  logic              borrow_i,
    output logic [BYTE_W-1:0] dout,
    output logic              borrow_o
);
    logic [DIGIT_W-1:0] lo, hi;

    always_comb begin
        lo       = din[DIGIT_W-1:0];
        hi       = din[BYTE_W-1:DIGIT_W];
        borrow_o = 1'b0;
        if (borrow_i) begin
            if (lo == '0) begin
                lo = DIGIT_W'(9);
                if (hi == '0) begin
                    hi       = DIGIT_W'(9);
                    borrow_o = 1'b1;
                end else begin
                    hi = hi - 1'b1;
                end
            end else begin
                lo = lo - 1'b1;
            end
        end
        dout = {hi, lo};
    end
endmodule

// File: rtl/wdt_pulse_gen.sv
module wdt_pulse_gen #(
    parameter int PULSE_CYCLES = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic fire_i,
    output logic pulse_o
);
    localparam int CNT_W = $clog2(PULSE_CYCLES + 1);

    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (fire_i)
            cnt_d = CNT_W'(PULSE_CYCLES);
        else if (cnt_q != '0)
            cnt_d = cnt_q - 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign pulse_o = (cnt_q != '0);

    // R6: pulse counter never exceeds its programmed length
    a_r6_pulse_bounded: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= CNT_W'(PULSE_CYCLES));
    // R6: without a new fire, a running pulse counts down by one
    a_r6_pulse_counts_down: assert property (@(posedge clk) disable iff (!rst_n)
        (!fire_i && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - 1'b1));
endmodule

// File: rtl/bcd_watchdog.sv
module bcd_watchdog
    import wdt_pkg::*;
#(
    parameter int              ADDR_W     = 4,
    parameter logic [ADDR_W-1:0] ADR_FRAC = 4'hC,
    parameter logic [ADDR_W-1:0] ADR_SECS = 4'hD,
    parameter logic [ADDR_W-1:0] ADR_STAT = 4'hE,
    parameter logic [ADDR_W-1:0] ADR_CTRL = 4'hF,
    parameter int              RST_CYCLES = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel_i,
    input  logic              bus_we_i,
    input  logic [ADDR_W-1:0] bus_addr_i,
    input  logic [BYTE_W-1:0] bus_wdata_i,
    output logic [BYTE_W-1:0] bus_rdata_o,
    input  logic              tick_i,
    output logic              wd_rst_o,
    output logic              wd_irq_o,
    output logic              wd_flag_o
);
    localparam logic [COUNT_W-1:0] LAST_COUNT = COUNT_W'(1);

    wdt_state_t s_d, s_q;

    logic wr_frac, wr_secs, wr_ctrl, wr_cnt, rd_stat;
    logic running, expire, fire;
    logic [COUNT_W-1:0] dec_val;
    logic [NBYTES:0]    borrow;

    // BCD decrement chain over the count bytes, hundredths first
    assign borrow[0] = 1'b1;
    for (genvar g = 0; g < NBYTES; g++) begin : g_dec
        wdt_bcd_byte_dec u_dec (
            .din      (s_q.work[g*BYTE_W +: BYTE_W]),
            .borrow_i (borrow[g]),
            .dout     (dec_val[g*BYTE_W +: BYTE_W]),
            .borrow_o (borrow[g+1])
        );
    end

    always_comb begin
        s_d     = s_q;
        wr_frac = bus_sel_i &&  bus_we_i && (bus_addr_i == ADR_FRAC);
        wr_secs = bus_sel_i &&  bus_we_i && (bus_addr_i == ADR_SECS);
        wr_ctrl = bus_sel_i &&  bus_we_i && (bus_addr_i == ADR_CTRL);
        rd_stat = bus_sel_i && !bus_we_i && (bus_addr_i == ADR_STAT);
        wr_cnt  = wr_frac || wr_secs;

        if (wr_frac) s_d.frac = bus_wdata_i;
        if (wr_secs) s_d.secs = bus_wdata_i;
        if (wr_ctrl) begin
            s_d.en    = bus_wdata_i[EN_BIT];
            s_d.steer = bus_wdata_i[STEER_BIT];
        end

        running = s_q.en && ({s_q.secs, s_q.frac} != '0);
        expire  = running && tick_i && !wr_cnt && (s_q.work == LAST_COUNT);
        fire    = expire && s_q.steer;

        if (!s_q.en || wr_cnt)
            s_d.work = {s_d.secs, s_d.frac};
        else if (expire)
            s_d.work = {s_q.secs, s_q.frac};
        else if (running && tick_i)
            s_d.work = dec_val;

        if (rd_stat) begin
            s_d.flag = 1'b0;
            s_d.irq  = 1'b0;
        end
        if (expire) begin
            s_d.flag = 1'b1;
            if (!s_q.steer) s_d.irq = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    always_comb begin
        bus_rdata_o = '0;
        if (bus_addr_i == ADR_FRAC)      bus_rdata_o = s_q.frac;
        else if (bus_addr_i == ADR_SECS) bus_rdata_o = s_q.secs;
        else if (bus_addr_i == ADR_STAT) bus_rdata_o[FLAG_BIT] = s_q.flag;
        else if (bus_addr_i == ADR_CTRL) begin
            bus_rdata_o[EN_BIT]    = s_q.en;
            bus_rdata_o[STEER_BIT] = s_q.steer;
        end
    end

    wdt_pulse_gen #(.PULSE_CYCLES(RST_CYCLES)) u_pulse (
        .clk     (clk),
        .rst_n   (rst_n),
        .fire_i  (fire),
        .pulse_o (wd_rst_o)
    );

    assign wd_irq_o  = s_q.irq;
    assign wd_flag_o = s_q.flag;

    // R6: a reset pulse only starts after a steered, enabled tick
    a_r6_rst_needs_steer: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(wd_rst_o) |-> $past(tick_i && s_q.en && s_q.steer));
    // R7: the interrupt only rises after a non-steered tick
    a_r7_irq_needs_tick: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(wd_irq_o) |-> $past(tick_i && !s_q.steer));
    // R9: the flag only rises from an enabled tick
    a_r9_flag_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(wd_flag_o) |-> $past(tick_i && s_q.en));
    // R8: a status read with no expiry clears the flag
    a_r8_read_clears_flag: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_stat && !expire) |=> !wd_flag_o);
    // R3: the enabled counter holds between ticks and writes
    a_r3_hold_without_tick: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.en && !tick_i && !wr_cnt) |=> $stable(s_q.work));
endmodule

// File: tb/tb_bcd_watchdog.sv
module tb_bcd_watchdog;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bus_sel = 1'b0, bus_we = 1'b0, tick = 1'b0;
    logic [3:0] bus_addr = '0;
    logic [7:0] bus_wdata = '0;
    logic [7:0] bus_rdata;
    logic       wd_rst, wd_irq, wd_flag;

    int n_checks = 0;
    int n_fail   = 0;
    byte exp_evt[$];

    always #10 clk = ~clk;

    bcd_watchdog dut (
        .clk(clk), .rst_n(rst_n),
        .bus_sel_i(bus_sel), .bus_we_i(bus_we), .bus_addr_i(bus_addr),
        .bus_wdata_i(bus_wdata), .bus_rdata_o(bus_rdata),
        .tick_i(tick), .wd_rst_o(wd_rst), .wd_irq_o(wd_irq), .wd_flag_o(wd_flag)
    );

    task automatic chk(string req, int act, int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    // monitor: each rising reset or interrupt must match the next expected event
    logic prev_rst = 1'b0, prev_irq = 1'b0;
    always @(negedge clk) begin
        if (rst_n) begin
            if ((wd_rst && !prev_rst) || (wd_irq && !prev_irq)) begin
                byte got;
                got = (wd_rst && !prev_rst) ? "R" : "I";
                if (exp_evt.size() == 0) chk("R6/R7 unexpected event", got, 0);
                else                     chk("R6/R7 event kind", got, exp_evt.pop_front());
            end
        end
        prev_rst = wd_rst;
        prev_irq = wd_irq;
    end

    task automatic wr(input logic [3:0] a, input logic [7:0] d);
        bus_sel = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(posedge clk); @(negedge clk);
        bus_sel = 1'b0; bus_we = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [7:0] d);
        bus_sel = 1'b1; bus_we = 1'b0; bus_addr = a;
        #1 d = bus_rdata;
        @(posedge clk); @(negedge clk);
        bus_sel = 1'b0;
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) begin
            tick = 1'b1;
            @(posedge clk); @(negedge clk);
            tick = 1'b0;
            @(posedge clk); @(negedge clk);
        end
    endtask

    task automatic clear_status();
        logic [7:0] d;
        rd(4'hE, d);
    endtask

    initial begin
        logic [7:0] d;
        int n;
        repeat (3) @(negedge clk);
        // R1: reset state
        for (int a = 12; a < 16; a++) begin
            bus_addr = 4'(a); #1;
            chk("R1 register reset value", bus_rdata, 0);
        end
        chk("R1 outputs low", {wd_rst, wd_irq, wd_flag}, 0);
        rst_n = 1'b1;
        @(negedge clk);

        // R2: register map and readback
        wr(4'hC, 8'h37); wr(4'hD, 8'h42);
        rd(4'hC, d); chk("R2 hundredths readback", d, 8'h37);
        rd(4'hD, d); chk("R2 seconds readback", d, 8'h42);
        wr(4'hF, 8'hFF);
        rd(4'hF, d); chk("R2 control bits 7:2 read 0", d, 8'h03);
        wr(4'hF, 8'h00);
        rd(4'h3, d); chk("R2 unmapped offset", d, 8'h00);

        // R11/R9: ticks while disabled do not count
        wr(4'hD, 8'h00); wr(4'hC, 8'h03);
        ticks(10);
        chk("R9 disabled no flag", wd_flag, 0);
        wr(4'hF, 8'h02);
        ticks(2);
        chk("R11 full count after enable", wd_flag, 0);
        exp_evt.push_back("I");
        ticks(1);
        chk("R3 expiry on tick N", wd_flag, 1);
        chk("R7 irq set", wd_irq, 1);
        chk("R7 no reset pulse", wd_rst, 0);

        // R8: status read returns and clears the flag
        rd(4'hE, d);
        chk("R8 status flag bit1", d, 8'h02);
        chk("R8 flag cleared", wd_flag, 0);
        chk("R8 irq cleared", wd_irq, 0);

        // R10: keeps running after expiry
        ticks(2);
        chk("R10 no early second expiry", wd_flag, 0);
        exp_evt.push_back("I");
        ticks(1);
        chk("R10 second expiry", wd_flag, 1);
        clear_status();

        // R4: BCD borrow, 01.05 -> 105 ticks
        wr(4'hD, 8'h01); wr(4'hC, 8'h05);
        ticks(104);
        chk("R4 no expiry at tick 104", wd_flag, 0);
        exp_evt.push_back("I");
        ticks(1);
        chk("R4 expiry at tick 105", wd_flag, 1);
        clear_status();

        // R5: kick restarts the count
        wr(4'hD, 8'h00); wr(4'hC, 8'h10);
        ticks(7);
        wr(4'hC, 8'h10);
        ticks(9);
        chk("R5 kick restarted count", wd_flag, 0);
        // R5: tick in same cycle as a kick write does not expire
        bus_sel = 1'b1; bus_we = 1'b1; bus_addr = 4'hD; bus_wdata = 8'h00; tick = 1'b1;
        @(posedge clk); @(negedge clk);
        bus_sel = 1'b0; bus_we = 1'b0; tick = 1'b0;
        chk("R5 kick wins over tick", wd_flag, 0);
        ticks(9);
        chk("R5 full count after colliding kick", wd_flag, 0);
        exp_evt.push_back("I");
        ticks(1);
        chk("R5 expiry after kick", wd_flag, 1);
        clear_status();

        // R6: steered expiry -> 16-cycle reset pulse
        wr(4'hF, 8'h03);
        wr(4'hC, 8'h04);
        ticks(3);
        chk("R6 no early pulse", wd_rst, 0);
        exp_evt.push_back("R");
        tick = 1'b1;
        @(posedge clk); @(negedge clk);
        tick = 1'b0;
        n = 0;
        while (wd_rst && n < 100) begin n++; @(negedge clk); end
        chk("R6 pulse length", n, 16);
        chk("R6 irq stays low", wd_irq, 0);
        chk("R8 flag on steered expiry", wd_flag, 1);
        clear_status();

        // R9: zero count stops the watchdog
        wr(4'hC, 8'h00); wr(4'hD, 8'h00);
        ticks(200);
        chk("R9 zero count no flag", wd_flag, 0);
        chk("R9 zero count no pulse", wd_rst, 0);

        // R8: read colliding with expiry keeps the flag
        wr(4'hF, 8'h02);
        wr(4'hC, 8'h02);
        ticks(1);
        exp_evt.push_back("I");
        bus_sel = 1'b1; bus_we = 1'b0; bus_addr = 4'hE; tick = 1'b1;
        #1 d = bus_rdata;
        @(posedge clk); @(negedge clk);
        bus_sel = 1'b0; tick = 1'b0;
        chk("R8 read data before expiry", d, 8'h00);
        chk("R8 expiry wins over read", wd_flag, 1);
        clear_status();
        chk("R8 later read clears", wd_flag, 0);

        // R9: clearing enable mid-count stops it
        wr(4'hC, 8'h05);
        ticks(3);
        wr(4'hF, 8'h00);
        ticks(10);
        chk("R9 disable mid-count", wd_flag, 0);

        chk("R6/R7 all expected events seen", exp_evt.size(), 0);
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_checks++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end
endmodule